// File: doc/BRIEF.md
# Synchronous Multiplexed Bus Slave Bridge

This bridge sits on the device side of a synchronous external bus. One 16-bit pin group carries first an address and then data. The group is framed by active-low strobes for chip select, address valid, output enable and direction. The host supplies the bus clock and runs it only while an access is in flight. The bridge latches the address, waits exactly one cycle, and then moves one 32-bit word as two 16-bit beats. On its inside it offers a plain register port: an address, a one-cycle read enable with a read data input, and a one-cycle write enable with write data.

Every access takes four bus clock edges:

- Address edge: chip select and address valid are both low, and the address is captured.
- Wait edge: on a read, the register port is read and its data is captured here.
- Low beat edge: bits 15..0 of the word are on the bus.
- High beat edge: bits 31..16 are on the bus. On a write, the internal write enable is asserted at this edge.

The controller has four named states: `ST_IDLE`, `ST_WAIT`, `ST_BEAT_LO` and `ST_BEAT_HI`. Its transitions are:

- **start**: `ST_IDLE` to `ST_WAIT`, on chip select and address valid both low.
- **settle**: `ST_WAIT` to `ST_BEAT_LO`.
- **advance**: `ST_BEAT_LO` to `ST_BEAT_HI`.
- **finish**: `ST_BEAT_HI` to `ST_IDLE`.
- **abort**: any state to `ST_IDLE` on a clock edge where chip select is high.

No strobe or state change depends on a clock edge arriving after the last beat. The bridge drives the shared pins only while a read beat is being presented. It does not use an inout port: it exposes the output value and an output enable for the pad ring.

Top module: `mbb_top`

## Requirements
- R1: The address is taken from `ad_i` on the clock edge where `cs_n` and `adv_n` are both low while idle. It appears unshifted on `reg_addr` and stays unchanged until the next address edge.
- R2: On a read (`we_n` high at the address edge), `reg_re` is high for exactly the one wait cycle that follows the address edge. It is low in every other cycle.
- R3: On a write (`we_n` low at the address edge), the first data beat carries word bits 15..0 and the second carries bits 31..16. `reg_wdata` equals {second beat, first beat}.
- R4: `reg_we` is high exactly once per completed write, during the second beat cycle, and is never high together with `reg_re`.
- R5: Read data is sampled from `reg_rdata` at the end of the wait cycle. `ad_o` shows bits 15..0 in the first beat and bits 31..16 in the second, even if `reg_rdata` changes after sampling.
- R6: `ad_oe` is high only in read beat cycles with `cs_n` and `oe_n` low. It is low during address and wait cycles, during writes (even with `oe_n` low) and while idle.
- R7: A clock edge with `cs_n` high returns the bridge to idle. An abandoned write produces no `reg_we`, and the target word keeps its value.
- R8: After reset, the bridge is idle, `reg_we`, `reg_re` and `ad_oe` are low, and `reg_addr` is zero.
- R9: An access completes in four clock edges. A new access may start after one idle edge with `cs_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock, host-supplied, runs only during accesses |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Direction: low = write, high = read |
| ad_i | input | 16 | Shared address/data pins, input side |
| ad_o | output | 16 | Shared pins, read data to drive |
| ad_oe | output | 1 | Drive enable for the shared pins |
| reg_addr | output | 16 | Register port address |
| reg_re | output | 1 | Register port read enable |
| reg_rdata | input | 32 | Register port read data |
| reg_we | output | 1 | Register port write enable |
| reg_wdata | output | 32 | Register port write data |

## Verification
The bench sweeps 16 addresses spread over the full 16-bit space, from 0x0000 to 0xFFFF in steps of 0x1111. It writes an arithmetically derived word to each address and then reads every word back. This shows whether the address is shifted or truncated, and whether the two beats are swapped or mixed up between words.

Some reads replace the register port data with a decoy right after the wait cycle. The beats must still show the sampled word, which separates a held sample from a live path. Writes are driven with `oe_n` low, so a bridge that drives the pins on writes is caught.

Accesses are aborted after the address edge and after the first beat. A write strobe count, plus a read-back of the aborted address, shows that an abandoned access leaves no trace.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_BEAT_LO = 2'd2,
        ST_BEAT_HI = 2'd3
    } mbb_state_t;
endpackage

// File: rtl/mbb_fsm.sv
module mbb_fsm
    import mbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       adv_n,
    input  logic       oe_n,
    input  logic       we_n,
    output mbb_state_t st,
    output logic       addr_load,
    output logic       rd_load,
    output logic       lo_load,
    output logic       reg_re,
    output logic       reg_we,
    output logic       drive
);
    mbb_state_t st_q, st_d;
    logic       rd_cyc_q;

    // Next-state decision; a high chip select at any edge aborts the access.
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:    if (!adv_n) st_d = ST_WAIT;
                ST_WAIT:    st_d = ST_BEAT_LO;
                ST_BEAT_LO: st_d = ST_BEAT_HI;
                ST_BEAT_HI: st_d = ST_IDLE;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // State register with the direction captured at the address edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            rd_cyc_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (addr_load) rd_cyc_q <= we_n;
        end
    end

    // Outputs decoded from the present state, qualified by chip select.
    always_comb begin
        addr_load = 1'b0;
        rd_load   = 1'b0;
        lo_load   = 1'b0;
        reg_re    = 1'b0;
        reg_we    = 1'b0;
        drive     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                addr_load = !cs_n && !adv_n;
            end
            ST_WAIT: begin
                reg_re  = rd_cyc_q && !cs_n;
                rd_load = rd_cyc_q && !cs_n;
            end
            ST_BEAT_LO: begin
                lo_load = !rd_cyc_q && !cs_n;
                drive   = rd_cyc_q && !cs_n && !oe_n;
            end
            ST_BEAT_HI: begin
                reg_we = !rd_cyc_q && !cs_n;
                drive  = rd_cyc_q && !cs_n && !oe_n;
            end
            default: ;
        endcase
    end

    assign st = st_q;

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (st_q == ST_IDLE));

    // R2
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
endmodule

// File: rtl/mbb_datapath.sv
module mbb_datapath
    import mbb_pkg::*;
#(
    parameter int BEAT_W = 16,
    parameter int ADDR_W = 16,
    localparam int WORD_W = 2 * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mbb_state_t        st,
    input  logic              addr_load,
    input  logic              rd_load,
    input  logic              lo_load,
    input  logic [BEAT_W-1:0] ad_i,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic [BEAT_W-1:0] ad_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] lo_q;
    logic [WORD_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            lo_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (addr_load) addr_q <= ad_i[ADDR_W-1:0];
            if (lo_load)   lo_q   <= ad_i;
            if (rd_load)   rd_q   <= reg_rdata;
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = {ad_i, lo_q};
    assign ad_o      = (st == ST_BEAT_HI) ? rd_q[WORD_W-1:BEAT_W] : rd_q[BEAT_W-1:0];

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(addr_q));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BEAT_LO) |=> $stable(rd_q));
endmodule

// File: rtl/mbb_top.sv
module mbb_top
    import mbb_pkg::*;
#(
    parameter int BEAT_W = 16,
    parameter int ADDR_W = 16,
    localparam int WORD_W = 2 * BEAT_W
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [BEAT_W-1:0] ad_i,
    output logic [BEAT_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_re,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata
);
    mbb_state_t st;
    logic       addr_load, rd_load, lo_load, drive;

    mbb_fsm u_fsm (
        .clk       (bclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .adv_n     (adv_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .st        (st),
        .addr_load (addr_load),
        .rd_load   (rd_load),
        .lo_load   (lo_load),
        .reg_re    (reg_re),
        .reg_we    (reg_we),
        .drive     (drive)
    );

    mbb_datapath #(
        .BEAT_W (BEAT_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk       (bclk),
        .rst_n     (rst_n),
        .st        (st),
        .addr_load (addr_load),
        .rd_load   (rd_load),
        .lo_load   (lo_load),
        .ad_i      (ad_i),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ad_o      (ad_o)
    );

    assign ad_oe = drive;

    // R6
    drive_beat_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        ad_oe |-> (st == ST_BEAT_LO || st == ST_BEAT_HI));
endmodule

// File: tb/tb_mbb_top.sv
`timescale 1ns/100ps
module tb_mbb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] ad_i = '0;
    logic [15:0] ad_o;
    logic        ad_oe;
    logic [15:0] reg_addr;
    logic        reg_re, reg_we;
    logic [31:0] reg_rdata, reg_wdata;

    logic [31:0] rf [0:255];
    logic        decoy = 1'b0;
    int          we_count = 0;
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    mbb_top dut (
        .bclk (clk), .rst_n (rst_n), .cs_n (cs_n), .adv_n (adv_n),
        .oe_n (oe_n), .we_n (we_n), .ad_i (ad_i), .ad_o (ad_o),
        .ad_oe (ad_oe), .reg_addr (reg_addr), .reg_re (reg_re),
        .reg_rdata (reg_rdata), .reg_we (reg_we), .reg_wdata (reg_wdata)
    );

    // Bench-side register file behind the register port.
    always_comb reg_rdata = decoy ? 32'hDEAD_BEEF : rf[reg_addr[7:0]];

    always @(posedge clk) begin
        if (reg_we) begin
            rf[reg_addr[7:0]] <= reg_wdata;
            we_count <= we_count + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int i, input logic [15:0] a);
        return (32'(i) * 32'h9E37_79B9) ^ {a, ~a};
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); cs_n = 0; adv_n = 0; we_n = 0; oe_n = 1; ad_i = a;
        #1 chk("R6 addr phase", {31'd0, ad_oe}, 0);
        @(negedge clk); adv_n = 1; ad_i = 16'h0;
        #1 chk("R1 addr", {16'd0, reg_addr}, {16'd0, a});
        chk("R2 no re on write", {31'd0, reg_re}, 0);
        @(negedge clk); ad_i = d[15:0]; oe_n = 0;
        #1 chk("R6 write beat", {31'd0, ad_oe}, 0);
        chk("R4 no early we", {31'd0, reg_we}, 0);
        @(negedge clk); ad_i = d[31:16];
        #1 chk("R4 we pulse", {31'd0, reg_we}, 1);
        chk("R3 wdata", reg_wdata, d);
        @(negedge clk); cs_n = 1; oe_n = 1; we_n = 1; ad_i = 16'h0;
        #1 chk("R4 we gone", {31'd0, reg_we}, 0);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [31:0] e, input logic scramble);
        @(negedge clk); cs_n = 0; adv_n = 0; we_n = 1; oe_n = 1; ad_i = a;
        #1 chk("R2 no re at addr", {31'd0, reg_re}, 0);
        @(negedge clk); adv_n = 1; oe_n = 0; ad_i = 16'h0;
        #1 chk("R2 re in wait", {31'd0, reg_re}, 1);
        chk("R1 addr", {16'd0, reg_addr}, {16'd0, a});
        chk("R6 wait not driven", {31'd0, ad_oe}, 0);
        @(negedge clk); if (scramble) decoy = 1;
        #1 chk("R6 read drive", {31'd0, ad_oe}, 1);
        chk("R5 low beat", {16'd0, ad_o}, {16'd0, e[15:0]});
        @(negedge clk);
        #1 chk("R5 high beat", {16'd0, ad_o}, {16'd0, e[31:16]});
        chk("R2 re once", {31'd0, reg_re}, 0);
        @(negedge clk); cs_n = 1; oe_n = 1; decoy = 0;
        #1 chk("R6 released", {31'd0, ad_oe}, 0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) rf[k] = 32'h0;
        repeat (3) @(negedge clk);
        #1 chk("R8 oe reset", {31'd0, ad_oe}, 0);
        chk("R8 we reset", {31'd0, reg_we}, 0);
        chk("R8 re reset", {31'd0, reg_re}, 0);
        chk("R8 addr reset", {16'd0, reg_addr}, 0);
        rst_n = 1;
        @(negedge clk);

        // R9: back-to-back accesses separated by one idle edge
        for (int i = 0; i < 16; i++) do_write(16'(i * 16'h1111), pattern(i, 16'(i * 16'h1111)));
        chk("R4 write count", 32'(we_count), 32'd16);
        for (int i = 0; i < 16; i++) do_read(16'(i * 16'h1111), pattern(i, 16'(i * 16'h1111)), i[0]);

        // R7: abort a write after the first beat
        @(negedge clk); cs_n = 0; adv_n = 0; we_n = 0; ad_i = 16'h3333;
        @(negedge clk); adv_n = 1; ad_i = 16'h0;
        @(negedge clk); ad_i = 16'hAAAA;
        @(negedge clk); cs_n = 1; ad_i = 16'h5555;
        #1 chk("R7 no we on abort", {31'd0, reg_we}, 0);
        @(negedge clk); we_n = 1;
        // R7: abort a read right after the address edge
        @(negedge clk); cs_n = 0; adv_n = 0; ad_i = 16'h4444;
        @(negedge clk); cs_n = 1; adv_n = 1;
        #1 chk("R7 no re on abort", {31'd0, reg_re}, 0);
        @(negedge clk);
        chk("R7 write count", 32'(we_count), 32'd16);
        do_read(16'h3333, pattern(3, 16'h3333), 1'b0);
        do_read(16'hFFFF, pattern(15, 16'hFFFF), 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule